// File: doc/BRIEF.md
# Idle-Time Drive Poll Scheduler

This block runs a short servicing slot, the poll pass, once per timebase tick while the disk controller has no command in progress. The tick period is a parameter given in clock cycles; at the nominal 500 kbps rate it stands for 1 ms. A pass has three duties. It reports ready-changed state for four logical drives. It issues one pending head step with the correct direction level. It moves the automatic low-power sequence forward once a motor-off timeout has run out.

After every reset all four ready-changed flags are set. The first pass then raises the interrupt, which is attributed to drive 0. Software must send one sense request per drive to clear the flags, and the interrupt drops once all four are clear. Software can remove this duty by writing the poll-off bit. Only writes that arrive within an acceptance window after reset count; the window is a parameter in ticks and stands for 500 ms. Step servicing and power-down sequencing keep running in the pass even when polling is off. When power-down is enabled, a motor-off pulse starts a wait of a parameterized number of ticks (512 ms nominal). At the end of that wait the next pass asserts the power-down request.

Top module: `dps_poll_sched`

## Requirements
- R1: While reset is held and on release, irq_o, step_o and pd_o are 0, and all four ready-changed flags are set.
- R2: A tick falls in every TICK_CYC-th clock cycle after reset release, and a pass is a tick cycle with idle_i high. When polling is on and any flag is set, irq_o rises in the cycle after the first pass.
- R3: Each sense_i pulse clears the lowest-numbered set flag. irq_o falls in the cycle after the pulse that clears the last flag. A sense pulse with no flag set has no effect, and later passes leave irq_o low.
- R4: A cfg_wr_i with cfg_poll_off_i=1, made while fewer than WIN_TICKS ticks have passed since reset, turns polling off and clears all flags, so irq_o does not rise.
- R5: A cfg_wr_i made after the window has closed is ignored: the polling state and irq_o do not change.
- R6: For a pass with a step pending, dir_o takes that drive's direction in the first cycle after the pass. step_o is 1 in the second cycle only, and dir_o keeps its value through the third cycle.
- R7: One pending drive is served per pass, lowest index first. Each drive uses the direction captured with its own request (step_dir_i bit i for drive i, 1 = outward level).
- R8: Stepping runs the same way whether polling is on or off.
- R9: A tick with idle_i low is not a pass: it issues no step and does not raise irq_o. Pending steps wait for a later pass.
- R10: With pd_en_i high, a moff_i pulse arms a wait. pd_o rises in the cycle after the pass on the PD_TICKS-th tick that follows the pulse, and not earlier.
- R11: pd_o never rises while pd_en_i is low. Dropping pd_en_i or idle_i clears pd_o and the armed wait in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, hardware or software |
| idle_i | input | 1 | Controller has no command in progress |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_poll_off_i | input | 1 | Poll-off bit carried by the configuration write |
| sense_i | input | 1 | Sense-interrupt request, one cycle per request |
| step_req_i | input | NDRV | Per-drive step request pulse |
| step_dir_i | input | NDRV | Per-drive direction, captured with the request |
| moff_i | input | 1 | Motor-off time expired pulse |
| pd_en_i | input | 1 | Automatic power-down enable |
| irq_o | output | 1 | Interrupt request |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Step direction level |
| pd_o | output | 1 | Power-down request |

## Verification
The bench keeps its own tick count from reset and uses it to target the edges of the timing rules. These are the first pass after reset, the last flag cleared by the fourth sense, and a configuration write on each side of the acceptance window. A design that miscounts the window would either keep the interrupt after an early poll-off write or drop it after a late one. A design that clears all flags on a single sense would drop the interrupt one to three requests too early. Random drive and direction choices check that dir_o is set up a cycle before step_o and held after it. Two requests pending together check the lowest-first order, where wrong order shows as a swapped direction. An off-by-one in the power-down wait shows as pd_o one pass early or late. Ticks taken with idle low check that no step or interrupt leaks out while a command is running.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } step_state_t;
endpackage

// File: rtl/dps_tick.sv
module dps_tick #(
  parameter int TICK_CYC  = 50000,
  parameter int WIN_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic win_open_o
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int WW = $clog2(WIN_TICKS + 1);

  logic [CW-1:0] cyc_q;
  logic [WW-1:0] win_q;

  function automatic logic at_end(input logic [CW-1:0] c);
    return c == CW'(TICK_CYC - 1);
  endfunction

  assign tick_o     = at_end(cyc_q);
  assign win_open_o = (win_q < WW'(WIN_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      win_q <= '0;
    end else begin
      cyc_q <= tick_o ? '0 : cyc_q + 1'b1;
      if (tick_o && win_open_o) win_q <= win_q + 1'b1;
    end
  end

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o || (TICK_CYC == 1));
endmodule

// File: rtl/dps_ready.sv
module dps_ready #(
  parameter int NDRV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_i,
  input  logic win_open_i,
  input  logic cfg_wr_i,
  input  logic cfg_off_i,
  input  logic sense_i,
  output logic irq_o
);
  logic [NDRV-1:0] flags_q, flags_n;
  logic            off_q, off_n;
  logic            cfg_take;

  function automatic logic [NDRV-1:0] drop_lowest(input logic [NDRV-1:0] v);
    return v & (v - 1'b1);
  endfunction

  assign cfg_take = cfg_wr_i && win_open_i;

  always_comb begin
    flags_n = flags_q;
    off_n   = off_q;
    if (sense_i) flags_n = drop_lowest(flags_q);
    if (cfg_take) begin
      off_n = cfg_off_i;
      if (cfg_off_i) flags_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '1;
      off_q   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      off_q   <= off_n;
      if (flags_n == '0)                 irq_o <= 1'b0;
      else if (pass_i && !off_n)         irq_o <= 1'b1;
    end
  end

  // R3
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |=> !irq_o);
  // R5
  late_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !win_open_i) |=> $stable(off_q));
  // R3
  sense_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && !cfg_wr_i && flags_q != '0) |=>
      ($countones(flags_q) + 1 == $countones($past(flags_q))));
endmodule

// File: rtl/dps_step.sv
module dps_step
  import dps_pkg::*;
#(
  parameter int NDRV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pass_i,
  input  logic [NDRV-1:0] req_i,
  input  logic [NDRV-1:0] dir_i,
  output logic            step_o,
  output logic            dir_o
);
  localparam int IW = (NDRV > 1) ? $clog2(NDRV) : 1;

  step_state_t     st_q;
  logic [NDRV-1:0] pend_q, pdir_q, clr;
  logic [IW-1:0]   sel;
  logic            launch;

  function automatic logic [IW-1:0] first_set(input logic [NDRV-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NDRV - 1; i >= 0; i--)
      if (v[i]) r = IW'(i);
    return r;
  endfunction

  assign sel    = first_set(pend_q);
  assign launch = pass_i && (pend_q != '0) && (st_q == ST_IDLE);
  assign clr    = launch ? (NDRV'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      pdir_q <= '0;
      step_o <= 1'b0;
      dir_o  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | req_i;
      for (int i = 0; i < NDRV; i++)
        if (req_i[i]) pdir_q[i] <= dir_i[i];
      unique case (st_q)
        ST_IDLE:  if (launch) begin
                    dir_o <= pdir_q[sel];
                    st_q  <= ST_SETUP;
                  end
        ST_SETUP: begin step_o <= 1'b1; st_q <= ST_PULSE; end
        ST_PULSE: begin step_o <= 1'b0; st_q <= ST_HOLD;  end
        ST_HOLD:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  step_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);
  // R6
  dir_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> $stable(dir_o));
  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_o) |-> $stable(dir_o));
  // R9
  step_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_o) |-> $past(pass_i, 2));
endmodule

// File: rtl/dps_pwrdn.sv
module dps_pwrdn #(
  parameter int PD_TICKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pass_i,
  input  logic idle_i,
  input  logic moff_i,
  input  logic pd_en_i,
  output logic pd_o
);
  localparam int PW = $clog2(PD_TICKS + 1);

  logic          armed_q;
  logic [PW-1:0] cnt_q;

  function automatic logic wait_done(input logic [PW-1:0] c);
    return c >= PW'(PD_TICKS - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pd_o    <= 1'b0;
    end else if (!idle_i || !pd_en_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pd_o    <= 1'b0;
    end else if (moff_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (tick_i && cnt_q < PW'(PD_TICKS)) cnt_q <= cnt_q + 1'b1;
      if (pass_i && wait_done(cnt_q)) pd_o <= 1'b1;
    end
  end

  // R11
  pd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_en_i |=> !pd_o);
  // R10
  pd_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_o) |-> ($past(pass_i) && $past(armed_q)));
endmodule

// File: rtl/dps_poll_sched.sv
module dps_poll_sched #(
  parameter int NDRV      = 4,
  parameter int TICK_CYC  = 50000,
  parameter int WIN_TICKS = 500,
  parameter int PD_TICKS  = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_i,
  input  logic            cfg_wr_i,
  input  logic            cfg_poll_off_i,
  input  logic            sense_i,
  input  logic [NDRV-1:0] step_req_i,
  input  logic [NDRV-1:0] step_dir_i,
  input  logic            moff_i,
  input  logic            pd_en_i,
  output logic            irq_o,
  output logic            step_o,
  output logic            dir_o,
  output logic            pd_o
);
  logic tick_w, win_open_w, pass_w;

  assign pass_w = tick_w && idle_i;

  dps_tick #(.TICK_CYC(TICK_CYC), .WIN_TICKS(WIN_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w), .win_open_o(win_open_w));

  dps_ready #(.NDRV(NDRV)) u_ready (
    .clk(clk), .rst_n(rst_n), .pass_i(pass_w), .win_open_i(win_open_w),
    .cfg_wr_i(cfg_wr_i), .cfg_off_i(cfg_poll_off_i), .sense_i(sense_i),
    .irq_o(irq_o));

  dps_step #(.NDRV(NDRV)) u_step (
    .clk(clk), .rst_n(rst_n), .pass_i(pass_w), .req_i(step_req_i),
    .dir_i(step_dir_i), .step_o(step_o), .dir_o(dir_o));

  dps_pwrdn #(.PD_TICKS(PD_TICKS)) u_pwrdn (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .pass_i(pass_w),
    .idle_i(idle_i), .moff_i(moff_i), .pd_en_i(pd_en_i), .pd_o(pd_o));

  // R9
  no_irq_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_w |=> !$rose(irq_o));
endmodule

// File: tb/dps_poll_sched_bench.sv
module dps_poll_sched_bench;
  localparam int NDRV = 4, TICK = 20, WIN = 8, PD = 6;

  logic clk = 0, rst_n = 0;
  logic idle = 0, cfg_wr = 0, cfg_off = 0, sense = 0, moff = 0, pd_en = 0;
  logic [NDRV-1:0] sreq = '0, sdir = '0;
  logic irq, step, dir, pd;
  int   checks = 0, errors = 0, bcnt = 0;

  always #5 clk = ~clk;

  dps_poll_sched #(.NDRV(NDRV), .TICK_CYC(TICK), .WIN_TICKS(WIN), .PD_TICKS(PD))
  u_dps_poll_sched (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .cfg_wr_i(cfg_wr),
    .cfg_poll_off_i(cfg_off), .sense_i(sense), .step_req_i(sreq),
    .step_dir_i(sdir), .moff_i(moff), .pd_en_i(pd_en), .irq_o(irq),
    .step_o(step), .dir_o(dir), .pd_o(pd));

  // bench view of R2: a tick in every TICK-th cycle after reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= 0;
    else        bcnt <= (bcnt == TICK - 1) ? 0 : bcnt + 1;

  function automatic bit is_tick(input int c);
    return c == TICK - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic idle_v);
    rst_n = 0; idle = idle_v; cfg_wr = 0; cfg_off = 0; sense = 0;
    moff = 0; pd_en = 0; sreq = '0; sdir = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic to_tick();
    do @(negedge clk); while (!is_tick(bcnt));
  endtask

  task automatic pulse_sense();
    sense = 1; @(negedge clk); sense = 0;
  endtask

  task automatic request(input int d, input logic dv);
    sreq[d] = 1; sdir[d] = dv; @(negedge clk); sreq = '0; sdir = '0;
  endtask

  // called at the negedge of the pass cycle
  task automatic check_step(input string req, input logic dv);
    @(negedge clk); chk(req, step, 0); chk(req, dir, dv);
    @(negedge clk); chk(req, step, 1); chk(req, dir, dv);
    @(negedge clk); chk(req, step, 0); chk(req, dir, dv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));

    // R1 reset state
    rst_n = 0; idle = 1;
    @(negedge clk);
    chk("R1 irq in reset", irq, 0); chk("R1 step in reset", step, 0);
    chk("R1 pd in reset", pd, 0);
    do_reset(1);
    chk("R1 irq after release", irq, 0);

    // R2 first pass raises interrupt
    to_tick(); chk("R2 irq before pass edge", irq, 0);
    @(negedge clk); chk("R2 irq after first pass", irq, 1);

    // R1/R3 four flags, one per sense
    for (int k = 0; k < 3; k++) begin
      pulse_sense(); chk("R3 irq held while flags remain", irq, 1);
    end
    pulse_sense(); chk("R3 irq falls on fourth sense", irq, 0);
    pulse_sense(); chk("R3 extra sense no effect", irq, 0);
    to_tick(); @(negedge clk); chk("R3 later pass keeps irq low", irq, 0);

    // R9 busy controller: no pass
    do_reset(0);
    request(0, 1);
    to_tick(); @(negedge clk); chk("R9 no irq with idle low", irq, 0);
    repeat (3) begin @(negedge clk); chk("R9 no step with idle low", step, 0); end
    idle = 1;
    to_tick(); check_step("R6 deferred step", 1);
    chk("R2 irq once idle", irq, 1);

    // R4 early poll-off write
    do_reset(1);
    @(negedge clk); cfg_wr = 1; cfg_off = 1; @(negedge clk); cfg_wr = 0; cfg_off = 0;
    to_tick(); @(negedge clk); chk("R4 poll off blocks irq", irq, 0);

    // R8 random steps with polling off
    for (int k = 0; k < 8; k++) begin
      int d; logic dv;
      d = $urandom % NDRV; dv = $urandom % 2;
      request(d, dv);
      to_tick(); check_step("R8 step with poll off", dv);
    end
    chk("R8 irq stays low", irq, 0);

    // R7 two pending: lowest first
    begin
      logic dv;
      dv = $urandom % 2;
      sreq = 4'b0110; sdir = {1'b0, ~dv, dv, 1'b0};
      @(negedge clk); sreq = '0; sdir = '0;
      to_tick(); check_step("R7 drive1 first", dv);
      to_tick(); check_step("R7 drive2 second", ~dv);
    end

    // R5 late poll-off write ignored
    do_reset(1);
    repeat (WIN + 1) to_tick();
    @(negedge clk); chk("R2 irq raised", irq, 1);
    cfg_wr = 1; cfg_off = 1; @(negedge clk); cfg_wr = 0; cfg_off = 0;
    to_tick(); @(negedge clk); chk("R5 late write ignored", irq, 1);
    repeat (4) pulse_sense();
    chk("R3 cleared after four senses", irq, 0);

    // R6 with polling on
    request(3, 0); to_tick(); check_step("R6 step dir 0", 0);
    request(2, 1); to_tick(); check_step("R6 step dir 1", 1);

    // R10 power-down wait
    pd_en = 1;
    to_tick(); @(negedge clk);
    moff = 1; @(negedge clk); moff = 0;
    for (int k = 0; k < PD - 1; k++) to_tick();
    @(negedge clk); chk("R10 pd not early", pd, 0);
    to_tick(); chk("R10 pd not before edge", pd, 0);
    @(negedge clk); chk("R10 pd after wait", pd, 1);
    idle = 0; @(negedge clk); chk("R11 idle drop clears pd", pd, 0);
    idle = 1;
    to_tick(); @(negedge clk); chk("R11 wait not kept", pd, 0);

    // R11 pd_en drop clears pd
    moff = 1; @(negedge clk); moff = 0;
    repeat (PD + 1) to_tick();
    @(negedge clk); chk("R10 pd second run", pd, 1);
    pd_en = 0; @(negedge clk); chk("R11 pd_en drop clears pd", pd, 0);

    // R11 disabled: never asserts
    to_tick(); @(negedge clk);
    moff = 1; @(negedge clk); moff = 0;
    repeat (PD + 2) to_tick();
    @(negedge clk); chk("R11 pd disabled", pd, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule